// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a synchronous requester and a 16-bit asynchronous static RAM. The requester presents a single-word read or write with an address, write data and two active-high byte-lane enables. The controller turns it into a strobe sequence on the memory pins: chip select, write strobe, output enable, active-low lane enables and the address, plus a drive-enable for its own data drivers. Every phase length is a whole number of clock cycles. Each count is worked out at elaboration from a clock-period parameter and a minimum time given in picoseconds.

Each access completes with a one-cycle ready pulse. For a read, the returned word is registered in that same cycle. After reset the controller refuses all accesses for a long start-up hold so that the memory supply can settle. After every read it keeps its data drivers off for long enough that the memory has released the bus before the controller drives it. During writes it never lowers output enable, so the memory cannot drive back while a write is under way. Between accesses every strobe rests inactive.

Top module: `sram_timing_ctrl`

## Requirements
- R1: Out of reset and between accesses, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_be_n is 2'b11, sram_dq_oe is 0 and req_ready is 0.
- R2: No access starts (sram_ce_n stays 1) until at least N_PWR = ceil(T_PWRUP_PS/CLK_PS) cycles after reset release, which is 50000 at the defaults. A request that is already pending waits for this.
- R3: A read (req_write=0) lowers sram_ce_n and sram_oe_n in the same cycle in which sram_addr takes the request address, and keeps sram_we_n at 1. The data bus is sampled N_RD = max of ceil(45 ns), ceil(45 ns) and ceil(22 ns) in cycles (12 at the defaults) after that edge, and the sampled word appears on rsp_rdata.
- R4: req_be[0] selects the low lane [7:0] and req_be[1] selects the high lane [15:8]. sram_be_n[0] and sram_be_n[1] are their active-low images. A disabled lane is not written and reads back as 8'h00.
- R5: A write (req_write=1) holds sram_we_n, sram_ce_n and the enabled lanes low for exactly N_WR = max of ceil(35 ns) and ceil(25 ns) in cycles (9 at the defaults), with address and data presented at the falling edge of sram_we_n. sram_oe_n stays 1 throughout every write.
- R6: req_ready pulses high for exactly one cycle per request. rsp_rdata holds the read word while req_ready is high.
- R7: After sram_oe_n rises, sram_dq_oe stays 0 for at least N_HZ = ceil(18 ns) cycles (5 at the defaults). sram_dq_oe is never 1 while sram_oe_n is 0.
- R8: Two access starts (falling edges of sram_ce_n) are at least N_CYC = ceil(45 ns) cycles apart (12 at the defaults).
- R9: Every count is ceil(minimum time / CLK_PS) and never less than 1. At the default 4 ns clock, the output-enable low width of a read is 12 cycles and the write-strobe low width is 9 cycles.
- R10: sram_addr and sram_dq_out stay unchanged for the whole write-strobe low time and at the cycle in which it rises. sram_dq_oe stays high until the recovery phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high lane enables, bit 0 = low byte |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_be_n | output | 2 | Memory lane enables, active low, bit 0 = low byte |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 16 | Data bus as seen from the memory |

## Verification
The assertions assume that the clock really runs at the CLK_PS period. They also assume that rst_n comes from a source that holds it low for at least two clock edges, so that the synchronizer settles. The controller samples the request fields only on the acceptance edge, so the assertions assume nothing about them. The stimulus holds every request stable from valid until ready and drops valid in the cycle after the pulse. Its memory model returns garbage until the read strobes have been low for the required number of cycles, and it puts a junk pattern on disabled lanes, so early sampling and missing masking both show up in the returned data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_BOOT   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_RD     = 3'd2,
    ST_RD_HIZ = 3'd3,
    ST_WR     = 3'd4,
    ST_WR_REC = 3'd5
  } seq_state_t;

  // whole clock cycles covering a minimum time, floor of one
  function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/sram_startup_hold.sv
module sram_startup_hold #(
  parameter int unsigned HOLD_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_d == CW'(HOLD_CYC));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R2

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_TIMER_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R9

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_RD   = 12,
  parameter int unsigned N_WR   = 9,
  parameter int unsigned N_REC  = 3,
  parameter int unsigned N_HZ   = 5,
  parameter int unsigned N_CYC  = 12,
  parameter int unsigned TW     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boot_done,
  input  logic                  tmr_zero,
  output logic                  tmr_load,
  output logic [TW-1:0]         tmr_val,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  req_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_ce_n,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic [DATA_W/8-1:0]   sram_be_n,
  output logic [DATA_W-1:0]     sram_dq_out,
  output logic                  sram_dq_oe,
  input  logic [DATA_W-1:0]     sram_dq_in
);

  localparam int unsigned NB = DATA_W / 8;

  seq_state_t            state_q, state_d;
  logic                  ce_q, ce_d, we_q, we_d, oe_q, oe_d;
  logic [NB-1:0]         be_q, be_d;
  logic                  dq_oe_q, dq_oe_d;
  logic                  ready_q, ready_d;
  logic                  accept, capture;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     wdata_q, rdata_q, rd_lanes;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    ce_d     = ce_q;
    we_d     = we_q;
    oe_d     = oe_q;
    be_d     = be_q;
    dq_oe_d  = dq_oe_q;
    ready_d  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        if (boot_done) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          ce_d     = 1'b0;
          be_d     = ~req_be;
          if (req_write) begin
            we_d    = 1'b0;
            dq_oe_d = 1'b1;
            tmr_val = TW'(N_WR - 1);
            state_d = ST_WR;
          end else begin
            oe_d    = 1'b0;
            tmr_val = TW'(N_RD - 1);
            state_d = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          capture  = 1'b1;
          ready_d  = 1'b1;
          ce_d     = 1'b1;
          oe_d     = 1'b1;
          be_d     = '1;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_HZ - 1);
          state_d  = ST_RD_HIZ;
        end
      end
      ST_RD_HIZ: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      ST_WR: begin
        if (tmr_zero) begin
          ready_d  = 1'b1;
          ce_d     = 1'b1;
          we_d     = 1'b1;
          be_d     = '1;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_REC - 1);
          state_d  = ST_WR_REC;
        end
      end
      ST_WR_REC: begin
        if (tmr_zero) begin
          dq_oe_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_BOOT;
    endcase
  end

  // lanes not enabled read back as zero
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      rd_lanes[i*8 +: 8] = be_q[i] ? 8'h00 : sram_dq_in[i*8 +: 8];
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      be_q    <= '1;
      dq_oe_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      we_q    <= we_d;
      oe_q    <= oe_d;
      be_q    <= be_d;
      dq_oe_q <= dq_oe_d;
      ready_q <= ready_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (accept && req_write) begin
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= rd_lanes;
    end
  end

  assign req_ready   = ready_q;
  assign rsp_rdata   = rdata_q;
  assign sram_addr   = addr_q;
  assign sram_ce_n   = ce_q;
  assign sram_we_n   = we_q;
  assign sram_oe_n   = oe_q;
  assign sram_be_n   = be_q;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = dq_oe_q;

  // checker state: elapsed-cycle counters observed by the properties below
  localparam int unsigned CW = $clog2(N_CYC + N_HZ + N_WR + 2);
  logic [CW-1:0] oe_hi_cnt, we_lo_cnt, gap_cnt;
  logic          ce_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= '1;
      we_lo_cnt <= '0;
      gap_cnt   <= '1;
      ce_prev   <= 1'b1;
    end else begin
      ce_prev   <= ce_q;
      oe_hi_cnt <= !oe_q ? '0 : ((oe_hi_cnt != '1) ? oe_hi_cnt + 1'b1 : oe_hi_cnt);
      we_lo_cnt <= we_q ? '0 : ((we_lo_cnt != '1) ? we_lo_cnt + 1'b1 : we_lo_cnt);
      if (ce_prev && !ce_q)     gap_cnt <= CW'(1);
      else if (gap_cnt != '1)   gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_OE_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_q && !oe_q)); // R5

  AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_q) |-> (we_lo_cnt >= CW'(N_WR))); // R5

  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_q |-> (oe_q && (oe_hi_cnt >= CW'(N_HZ)))); // R7

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q); // R6

  AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> (ce_q && we_q && oe_q)); // R2

  AST_CYCLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_q) |-> (gap_cnt >= CW'(N_CYC))); // R8

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_q && $past(!we_q)) |-> ($stable(addr_q) && $stable(wdata_q))); // R10

endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PS     = 4000,
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned T_CYC_PS   = 45000,
  parameter int unsigned T_AA_PS    = 45000,
  parameter int unsigned T_OE_PS    = 22000,
  parameter int unsigned T_WP_PS    = 35000,
  parameter int unsigned T_WEND_PS  = 35000,
  parameter int unsigned T_DS_PS    = 25000,
  parameter int unsigned T_HZ_PS    = 18000,
  parameter int unsigned T_PWRUP_PS = 200000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  req_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_ce_n,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic [DATA_W/8-1:0]   sram_be_n,
  output logic [DATA_W-1:0]     sram_dq_out,
  output logic                  sram_dq_oe,
  input  logic [DATA_W-1:0]     sram_dq_in
);

  localparam int unsigned N_CYC = cycles_for(T_CYC_PS, CLK_PS);
  localparam int unsigned N_RD  = max3(N_CYC, cycles_for(T_AA_PS, CLK_PS), cycles_for(T_OE_PS, CLK_PS));
  localparam int unsigned N_WR  = max3(cycles_for(T_WP_PS, CLK_PS), cycles_for(T_WEND_PS, CLK_PS),
                                       cycles_for(T_DS_PS, CLK_PS));
  localparam int unsigned N_REC = (N_CYC > N_WR) ? (N_CYC - N_WR) : 1;
  localparam int unsigned N_HZ  = cycles_for(T_HZ_PS, CLK_PS);
  localparam int unsigned N_PWR = cycles_for(T_PWRUP_PS, CLK_PS);
  localparam int unsigned TW    = $clog2(max3(max3(N_RD, N_WR, N_REC), N_HZ, 1) + 1);

  logic          rst_n_s;
  logic          boot_done;
  logic          tmr_zero, tmr_load;
  logic [TW-1:0] tmr_val;

  sram_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sram_startup_hold #(.HOLD_CYC(N_PWR)) u_hold (
    .clk   (clk),
    .rst_n (rst_n_s),
    .done  (boot_done)
  );

  sram_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_RD   (N_RD),
    .N_WR   (N_WR),
    .N_REC  (N_REC),
    .N_HZ   (N_HZ),
    .N_CYC  (N_CYC),
    .TW     (TW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .boot_done   (boot_done),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_be      (req_be),
    .req_ready   (req_ready),
    .rsp_rdata   (rsp_rdata),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_be_n   (sram_be_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_dq_in  (sram_dq_in)
  );

  initial begin
    AST_COUNTS_POSITIVE: assert (N_RD >= 1 && N_WR >= 1 && N_REC >= 1 && N_HZ >= 1); // R9
  end

endmodule

// File: tb/sram_timing_ctrl_tb_top.sv
module sram_timing_ctrl_tb_top;

  // expected counts at a 4 ns clock, worked out by hand from the requirements
  localparam int NRD  = 12;     // 45 ns / 4 ns rounded up
  localparam int NWR  = 9;      // 35 ns / 4 ns rounded up
  localparam int NHZ  = 5;      // 18 ns / 4 ns rounded up
  localparam int NCYC = 12;     // 45 ns / 4 ns rounded up
  localparam int NPWR = 50000;  // 200 us / 4 ns

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b00;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_out;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_in;

  always #2 clk = ~clk;  // 250 MHz

  sram_timing_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_be      (req_be),
    .req_ready   (req_ready),
    .rsp_rdata   (rsp_rdata),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_be_n   (sram_be_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_dq_in  (sram_dq_in)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lim);
    n_cmp++;
    if (act < lim) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected >= %0d", tag, act, lim);
    end
  endtask

  // ---------------- memory model and bus monitor ----------------
  logic [15:0] mem [256];
  int  ncyc = 0, rel_cyc = 0;
  int  we_lo = 0, last_wp = 0, oe_lo = 0, last_oe = 0, oe_hi = 1000, rd_stab = 0;
  int  first_start = -1, last_start = 0, min_gap = 1000000;
  int  viol_bus = 0, viol_ovl = 0, viol_hold = 0;
  bit  we_prev = 1'b1, oe_prev = 1'b1, ce_prev = 1'b1;
  logic [16:0] hold_addr = '0;
  logic [15:0] hold_data = '0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  end

  always @(negedge clk) begin
    ncyc++;
    if (!sram_we_n) begin
      if (!we_prev && ((sram_addr !== hold_addr) || (sram_dq_out !== hold_data))) viol_hold++;
      if (!sram_dq_oe) viol_hold++;
      hold_addr = sram_addr;
      hold_data = sram_dq_out;
      we_lo++;
      if (!sram_ce_n) begin
        if (!sram_be_n[0]) mem[sram_addr[7:0]][7:0]  = sram_dq_out[7:0];
        if (!sram_be_n[1]) mem[sram_addr[7:0]][15:8] = sram_dq_out[15:8];
      end
    end else begin
      if (!we_prev) begin
        last_wp = we_lo;
        if ((sram_addr !== hold_addr) || (sram_dq_out !== hold_data) || !sram_dq_oe) viol_hold++;
      end
      we_lo = 0;
    end
    we_prev = sram_we_n;

    if (!sram_we_n && !sram_oe_n) viol_ovl++;

    if (!sram_oe_n) oe_lo++;
    else begin
      if (!oe_prev) last_oe = oe_lo;
      oe_lo = 0;
    end
    oe_prev = sram_oe_n;

    if (sram_dq_oe && (!sram_oe_n || oe_hi < NHZ)) viol_bus++;
    if (sram_oe_n) begin
      if (oe_hi < 1000) oe_hi++;
    end else oe_hi = 0;

    if (!sram_ce_n && !sram_oe_n) rd_stab++;
    else rd_stab = 0;

    if (!sram_ce_n && ce_prev) begin
      if (first_start < 0) first_start = ncyc;
      else if (ncyc - last_start < min_gap) min_gap = ncyc - last_start;
      last_start = ncyc;
    end
    ce_prev = sram_ce_n;
  end

  // data valid only once strobes have been low long enough; junk on disabled lanes
  always_comb begin
    if (!sram_ce_n && !sram_oe_n && rd_stab >= NRD) begin
      sram_dq_in[7:0]  = sram_be_n[0] ? 8'hEE : mem[sram_addr[7:0]][7:0];
      sram_dq_in[15:8] = sram_be_n[1] ? 8'hEE : mem[sram_addr[7:0]][15:8];
    end else begin
      sram_dq_in = 16'hBAD0;
    end
  end

  // ---------------- request driver ----------------
  task automatic xfer(input bit wr, input logic [16:0] a, input logic [15:0] d,
                      input logic [1:0] be, output logic [15:0] rd);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    do @(negedge clk); while (!req_ready);
    rd = rsp_rdata;
    req_valid = 1'b0;
    @(negedge clk);
    chk_eq("R6 ready drops after one cycle", {31'd0, req_ready}, 32'd0);
  endtask

  task automatic check_rest(input string tag);
    chk_eq(tag, {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe, req_ready},
           {27'd0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    check_rest("R1 strobes inactive in reset");
    rst_n = 1'b1;
    rel_cyc = ncyc;
    repeat (10) @(negedge clk);
    check_rest("R1 strobes inactive after reset release");
  endtask

  task automatic t_boot_hold;
    logic [15:0] rd;
    xfer(1'b1, 17'h00033, 16'h0F0F, 2'b11, rd);
    chk_ge("R2 first access after start-up hold", first_start - rel_cyc, NPWR);
  endtask

  task automatic t_full_word;
    logic [15:0] rd;
    xfer(1'b1, 17'h00012, 16'h1234, 2'b11, rd);
    chk_eq("R5 R9 write strobe width", last_wp, NWR);
    repeat (NHZ + 2) @(negedge clk);
    check_rest("R1 rest between accesses");
    xfer(1'b0, 17'h00012, 16'h0000, 2'b11, rd);
    chk_eq("R3 read back full word", {16'd0, rd}, 32'h1234);
    chk_eq("R3 R9 read strobe width", last_oe, NRD);
    xfer(1'b0, 17'h00033, 16'h0000, 2'b11, rd);
    chk_eq("R3 read back start-up write", {16'd0, rd}, 32'h0F0F);
  endtask

  task automatic t_lanes;
    logic [15:0] rd;
    xfer(1'b1, 17'h00020, 16'hAAAA, 2'b11, rd);
    xfer(1'b1, 17'h00020, 16'h5555, 2'b01, rd);
    xfer(1'b0, 17'h00020, 16'h0000, 2'b11, rd);
    chk_eq("R4 low-lane write keeps high lane", {16'd0, rd}, 32'hAA55);
    xfer(1'b1, 17'h00020, 16'h3C3C, 2'b10, rd);
    xfer(1'b0, 17'h00020, 16'h0000, 2'b11, rd);
    chk_eq("R4 high-lane write keeps low lane", {16'd0, rd}, 32'h3C55);
    xfer(1'b0, 17'h00020, 16'h0000, 2'b10, rd);
    chk_eq("R4 high-lane read zeroes low lane", {16'd0, rd}, 32'h3C00);
    xfer(1'b0, 17'h00020, 16'h0000, 2'b01, rd);
    chk_eq("R4 low-lane read zeroes high lane", {16'd0, rd}, 32'h0055);
  endtask

  task automatic t_back_to_back;
    logic [15:0] rd;
    xfer(1'b0, 17'h00012, 16'h0000, 2'b11, rd);
    xfer(1'b1, 17'h00040, 16'hC0DE, 2'b11, rd);
    xfer(1'b0, 17'h00040, 16'h0000, 2'b11, rd);
    chk_eq("R3 read after write to new address", {16'd0, rd}, 32'hC0DE);
    xfer(1'b0, 17'h00012, 16'h0000, 2'b11, rd);
    xfer(1'b1, 17'h00041, 16'hBEEF, 2'b11, rd);
    xfer(1'b1, 17'h00042, 16'hF00D, 2'b11, rd);
    xfer(1'b0, 17'h00041, 16'h0000, 2'b11, rd);
    chk_eq("R5 write-write-read keeps first word", {16'd0, rd}, 32'hBEEF);
    repeat (NHZ + 2) @(negedge clk);
    check_rest("R1 rest after traffic");
    chk_eq("R7 no driver overlap with memory", viol_bus, 0);
    chk_eq("R5 output enable high during writes", viol_ovl, 0);
    chk_eq("R10 address and data held through write", viol_hold, 0);
    chk_ge("R8 spacing between access starts", min_gap, NCYC);
  endtask

  initial begin
    t_reset_state();
    t_boot_hold();
    t_full_word();
    t_lanes();
    t_back_to_back();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule